// File: doc/BRIEF.md
# Prioritized ADC Sample Sequencer

This block lets four independent capture programs share one single-channel analog-to-digital converter. Each program, called a sequence, has its own list of steps. Each step names a converter channel and carries a four-bit control nibble. Each sequence also has its own trigger source, a two-bit priority, an enable bit and a result FIFO. When one or more enabled sequences have a trigger pending, the sequencer hands the converter to the one with the best priority. It then walks that sequence's steps from step 0 upward. For each step it issues a start pulse with the step's channel, waits for the converter's done strobe, and pushes the result into that sequence's FIFO.

Software configures the block through a simple word-wide register port. A read of a FIFO data location pops that FIFO. Per-sequence interrupt, overflow and underflow flags are cleared by writing 1 to them. The converter itself sits outside the block, behind a start, channel, done and result handshake.

The four sequences have different capacities: 8 steps, 4 steps, 4 steps and 1 step. Each FIFO is as deep as its sequence.

Top module: `adc_seq_top`

## Requirements
- R1: After reset every FIFO reads empty with a count of zero, all interrupt, overflow and underflow flags read zero, and no conversion is started.
- R2: A granted sequence converts its steps from step 0 upward. The channel of step k is the nibble at bits [4k+3:4k] of the sequence's channel register. The run stops after the step whose control nibble has its end bit set (bit 1), or after the sequence's last available step if no end bit is set.
- R3: Each result goes into the FIFO of the sequence that produced it, in step order. It is read from the sequence's data address, which is 16 + 4n + 2.
- R4: Priority register bits [2n+1:2n] hold the priority of sequence n, where 0 is the best. Among the enabled sequences with a pending trigger, the one with the lowest priority value is granted when the converter is idle.
- R5: Writing 1 to bit n of the software trigger register (address 3) triggers sequence n. A sequence whose bit in the enable register (address 0) is 0 ignores all triggers.
- R6: The event-select register (address 1) has a 4-bit field at bits [4n+3:4n] for sequence n. The value 0 means software trigger only. A value k from 1 to 4 means a high cycle on ext_trig[k-1] triggers the sequence. The value 15 means the sequence is always triggered and rescans continuously.
- R7: A trigger that arrives while the same sequence is running is held, and the sequence runs a second pass after the current one.
- R8: A step whose control nibble has the interrupt bit set (bit 2) sets the sequence's raw interrupt bit when it completes. The raw bits read at address 4. irq and the status register at address 6 both show raw AND mask, where the mask is at address 5.
- R9: Writing 1 to a bit of the status register clears that raw bit. A write to the mask register that newly enables a bit first clears that sequence's stale raw bit.
- R10: A result that arrives when its FIFO is full is dropped and the stored contents are kept. This sets the sequence's bit in the overflow register (address 7), which is cleared by writing 1.
- R11: Reading the data address of an empty FIFO returns 0 and sets the sequence's bit in the underflow register (address 8), which is cleared by writing 1.
- R12: The FIFO status word at address 16 + 4n + 3 has empty in bit 0, full in bit 1 and the entry count in bits [7:4].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_trig | input | 4 | External trigger lines, active high for one or more cycles |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops a FIFO at a data address) |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the same cycle as reg_rd |
| conv_start | output | 1 | One-cycle request to start a conversion |
| conv_chan | output | 4 | Channel to convert, valid with conv_start |
| conv_done | input | 1 | Converter completion strobe |
| conv_result | input | 10 | Conversion result, valid with conv_done |
| irq | output | 4 | Per-sequence interrupt, raw AND mask |

## Verification
The bench focuses on these cases:
- Simultaneous triggers on three sequences with scrambled priorities. A design that arbitrates by index instead of by priority value would emit the channel stream in the wrong order.
- A second trigger that arrives mid-run. A design that drops this trigger would stop at 8 conversions instead of 16.
- A run into a full FIFO. A design that overwrites on overflow would return the newer result instead of the kept first one.
- Reads of an empty FIFO, which must return zero and raise underflow.
- A mask enable over a stale raw bit. A design that skips the pre-clear would fire the interrupt at once.
- An always-triggered sequence, which must keep scanning until it is disabled and then go quiet.
- An external line that the sequence did not select, which must start nothing.

// File: rtl/adc_seq_pkg.sv
`timescale 1ns/1ps
package adc_seq_pkg;
  localparam int NSEQ = 4;
  // bit positions inside a step's control nibble
  localparam int CTL_DIFF = 0;
  localparam int CTL_END  = 1;
  localparam int CTL_IE   = 2;
  localparam int CTL_TEMP = 3;

  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_WAIT} eng_state_t;

  function automatic int depth_of(int n, int d_first, int d_mid, int d_last);
    if (n == 0) return d_first;
    else if (n == NSEQ - 1) return d_last;
    else return d_mid;
  endfunction

  function automatic logic [3:0] nibble(logic [31:0] w, int idx);
    return w[idx*4 +: 4];
  endfunction

  function automatic logic [1:0] prio_of(logic [2*NSEQ-1:0] p, int n);
    return p[2*n +: 2];
  endfunction
endpackage

// File: rtl/adc_seq_fifo.sv
`timescale 1ns/1ps
module adc_seq_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 10,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic          empty,
  output logic          full,
  output logic [CW-1:0] count,
  output logic          drop
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] rp, wp;
  logic          do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign drop    = push && full;
  assign dout    = empty ? '0 : mem[rp];

  function automatic logic [PW-1:0] bump(logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rp <= '0;
      wp <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= bump(wp);
      if (do_pop)  rp <= bump(rp);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R10
  fifo_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> (full && $stable(count)));
  // R12
  fifo_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
endmodule

// File: rtl/adc_seq_arb.sv
`timescale 1ns/1ps
module adc_seq_arb
  import adc_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSEQ-1:0]   req,
  input  logic [2*NSEQ-1:0] prio,
  output logic              vld,
  output logic [1:0]        win
);
  logic [1:0] best;
  logic       found;

  always_comb begin
    best  = 2'd3;
    found = 1'b0;
    win   = 2'd0;
    for (int n = 0; n < NSEQ; n++) begin
      if (req[n] && (!found || prio_of(prio, n) < best)) begin
        found = 1'b1;
        best  = prio_of(prio, n);
        win   = 2'(n);
      end
    end
    vld = found;
  end

  for (genvar m = 0; m < NSEQ; m++) begin : g_chk
    // R4
    arb_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vld && req[m]) |-> (req[win] && prio_of(prio, int'(win)) <= prio_of(prio, m)));
  end
endmodule

// File: rtl/adc_seq_engine.sv
`timescale 1ns/1ps
module adc_seq_engine
  import adc_seq_pkg::*;
#(
  parameter int RES_W   = 10,
  parameter int D_FIRST = 8,
  parameter int D_MID   = 4,
  parameter int D_LAST  = 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  grant_vld,
  input  logic [1:0]            grant_seq,
  output logic                  take,
  input  logic [NSEQ-1:0][31:0] chan_cfg,
  input  logic [NSEQ-1:0][31:0] ctrl_cfg,
  output logic                  conv_start,
  output logic [3:0]            conv_chan,
  input  logic                  conv_done,
  input  logic [RES_W-1:0]      conv_result,
  output logic [NSEQ-1:0]       push,
  output logic [RES_W-1:0]      push_data,
  output logic [NSEQ-1:0]       ie_hit
);
  localparam int SW = (D_FIRST > 1) ? $clog2(D_FIRST) : 1;

  eng_state_t    state;
  logic [1:0]    cur;
  logic [SW-1:0] step;
  logic [3:0]    step_ctl;
  logic          last_step, step_done;

  assign step_ctl   = nibble(ctrl_cfg[cur], int'(step));
  assign conv_chan  = nibble(chan_cfg[cur], int'(step));
  assign conv_start = (state == ST_START);
  assign take       = (state == ST_IDLE) && grant_vld;
  assign step_done  = (state == ST_WAIT) && conv_done;
  assign last_step  = step_ctl[CTL_END] ||
                      (int'(step) == depth_of(int'(cur), D_FIRST, D_MID, D_LAST) - 1);
  assign push_data  = conv_result;

  always_comb begin
    for (int n = 0; n < NSEQ; n++) begin
      push[n]   = step_done && (cur == 2'(n));
      ie_hit[n] = step_done && (cur == 2'(n)) && step_ctl[CTL_IE];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cur   <= '0;
      step  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (grant_vld) begin
          cur   <= grant_seq;
          step  <= '0;
          state <= ST_START;
        end
        ST_START: state <= ST_WAIT;
        ST_WAIT: if (conv_done) begin
          if (last_step) state <= ST_IDLE;
          else begin
            step  <= step + 1'b1;
            state <= ST_START;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);
  // R2
  step_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_done && !last_step) |=> (conv_start && step == SW'($past(step) + 1'b1)));
  // R2
  run_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_done && last_step) |=> (state == ST_IDLE && !conv_start));
endmodule

// File: rtl/adc_seq_top.sv
`timescale 1ns/1ps
module adc_seq_top
  import adc_seq_pkg::*;
#(
  parameter int RES_W   = 10,
  parameter int N_EXT   = 4,
  parameter int D_FIRST = 8,
  parameter int D_MID   = 4,
  parameter int D_LAST  = 1,
  parameter int AW      = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EXT-1:0] ext_trig,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [AW-1:0]    reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic             conv_start,
  output logic [3:0]       conv_chan,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_result,
  output logic [NSEQ-1:0]  irq
);
  localparam logic [AW-1:0] A_ENA = 0, A_EVSEL = 1, A_PRIO = 2, A_SWTRIG = 3,
                            A_RAW = 4, A_MASK = 5, A_ISTAT = 6, A_OVF = 7, A_UNF = 8;
  localparam int A_SEQ = 16;
  localparam int EV_ALWAYS = 15;

  logic [NSEQ-1:0]        ena, mask, raw, ovf, unf, pend, trig_evt, take_vec;
  logic [4*NSEQ-1:0]      evsel;
  logic [2*NSEQ-1:0]      prio;
  logic [NSEQ-1:0][31:0]  chan_cfg, ctrl_cfg;
  logic [NSEQ-1:0]        push, ie_hit, pop, f_empty, f_full, f_drop, rd_empty;
  logic [NSEQ-1:0][RES_W-1:0] f_data;
  logic [NSEQ-1:0][3:0]   f_cnt;
  logic [RES_W-1:0]       push_data;
  logic                   grant_vld, take;
  logic [1:0]             grant_seq;
  logic [NSEQ-1:0]        sw_trig, istat_clr, mask_clr;

  function automatic logic hit(logic s, logic [AW-1:0] a, logic [AW-1:0] want);
    return s && (a == want);
  endfunction

  assign sw_trig   = hit(reg_wr, reg_addr, A_SWTRIG) ? reg_wdata[NSEQ-1:0] : '0;
  assign istat_clr = hit(reg_wr, reg_addr, A_ISTAT)  ? reg_wdata[NSEQ-1:0] : '0;
  assign mask_clr  = hit(reg_wr, reg_addr, A_MASK)   ? (reg_wdata[NSEQ-1:0] & ~mask) : '0;
  assign irq       = raw & mask;

  always_comb begin
    for (int n = 0; n < NSEQ; n++) begin
      logic [3:0] ev;
      ev = evsel[4*n +: 4];
      trig_evt[n] = sw_trig[n] || (int'(ev) == EV_ALWAYS) ||
                    (ev != 4'd0 && int'(ev) <= N_EXT && ext_trig[int'(ev) - 1]);
      take_vec[n] = take && (grant_seq == 2'(n));
      pop[n]      = hit(reg_rd, reg_addr, AW'(A_SEQ + 4*n + 2));
      rd_empty[n] = pop[n] && f_empty[n];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ena <= '0; mask <= '0; raw <= '0; ovf <= '0; unf <= '0; pend <= '0;
      evsel <= '0; prio <= '0; chan_cfg <= '0; ctrl_cfg <= '0;
    end else begin
      pend <= ena & ((pend & ~take_vec) | trig_evt);
      raw  <= (raw & ~(istat_clr | mask_clr)) | ie_hit;
      ovf  <= (ovf & ~(hit(reg_wr, reg_addr, A_OVF) ? reg_wdata[NSEQ-1:0] : '0)) | f_drop;
      unf  <= (unf & ~(hit(reg_wr, reg_addr, A_UNF) ? reg_wdata[NSEQ-1:0] : '0)) | rd_empty;
      if (reg_wr) begin
        case (reg_addr)
          A_ENA:   ena   <= reg_wdata[NSEQ-1:0];
          A_EVSEL: evsel <= reg_wdata[4*NSEQ-1:0];
          A_PRIO:  prio  <= reg_wdata[2*NSEQ-1:0];
          A_MASK:  mask  <= reg_wdata[NSEQ-1:0];
          default: ;
        endcase
        for (int n = 0; n < NSEQ; n++) begin
          if (reg_addr == AW'(A_SEQ + 4*n))     chan_cfg[n] <= reg_wdata;
          if (reg_addr == AW'(A_SEQ + 4*n + 1)) ctrl_cfg[n] <= reg_wdata;
        end
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr[AW-1]) begin
      case (reg_addr[1:0])
        2'd0: reg_rdata = chan_cfg[reg_addr[3:2]];
        2'd1: reg_rdata = ctrl_cfg[reg_addr[3:2]];
        2'd2: reg_rdata = 32'(f_data[reg_addr[3:2]]);
        default: reg_rdata = {24'd0, f_cnt[reg_addr[3:2]], 2'b00,
                              f_full[reg_addr[3:2]], f_empty[reg_addr[3:2]]};
      endcase
    end else begin
      case (reg_addr)
        A_ENA:   reg_rdata = 32'(ena);
        A_EVSEL: reg_rdata = 32'(evsel);
        A_PRIO:  reg_rdata = 32'(prio);
        A_RAW:   reg_rdata = 32'(raw);
        A_MASK:  reg_rdata = 32'(mask);
        A_ISTAT: reg_rdata = 32'(raw & mask);
        A_OVF:   reg_rdata = 32'(ovf);
        A_UNF:   reg_rdata = 32'(unf);
        default: reg_rdata = '0;
      endcase
    end
  end

  adc_seq_arb u_arb (
    .clk(clk), .rst_n(rst_n), .req(pend), .prio(prio), .vld(grant_vld), .win(grant_seq)
  );

  adc_seq_engine #(.RES_W(RES_W), .D_FIRST(D_FIRST), .D_MID(D_MID), .D_LAST(D_LAST)) u_eng (
    .clk(clk), .rst_n(rst_n), .grant_vld(grant_vld), .grant_seq(grant_seq), .take(take),
    .chan_cfg(chan_cfg), .ctrl_cfg(ctrl_cfg), .conv_start(conv_start), .conv_chan(conv_chan),
    .conv_done(conv_done), .conv_result(conv_result), .push(push), .push_data(push_data),
    .ie_hit(ie_hit)
  );

  for (genvar n = 0; n < NSEQ; n++) begin : g_seq
    localparam int D  = depth_of(n, D_FIRST, D_MID, D_LAST);
    localparam int CL = $clog2(D + 1);
    logic [CL-1:0] cnt;
    adc_seq_fifo #(.DEPTH(D), .W(RES_W), .CW(CL)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push(push[n]), .din(push_data), .pop(pop[n]),
      .dout(f_data[n]), .empty(f_empty[n]), .full(f_full[n]), .count(cnt), .drop(f_drop[n])
    );
    assign f_cnt[n] = 4'(cnt);

    // R9
    istat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit(reg_wr, reg_addr, A_ISTAT) && reg_wdata[n] && !ie_hit[n]) |=> !irq[n]);
    // R11
    unf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_empty[n] |=> unf[n]);
    // R5
    disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ena[n] |=> !pend[n]);
  end
endmodule

// File: tb/tb_adc_seq_top.sv
`timescale 1ns/1ps
module tb_adc_seq_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [3:0]  ext_trig = '0;
  logic        reg_wr = 0, reg_rd = 0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        conv_start;
  logic [3:0]  conv_chan;
  logic        conv_done = 0;
  logic [9:0]  conv_result = '0;
  logic [3:0]  irq;

  int checks = 0, errors = 0, conv_cnt = 0;
  int salt = 17;
  bit chk_en = 1;
  logic [3:0] exp_chan[$];
  int m_cnt = 0;
  logic [3:0] m_chan;

  always #10 clk = ~clk;

  adc_seq_top dut (
    .clk(clk), .rst_n(rst_n), .ext_trig(ext_trig), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .conv_start(conv_start), .conv_chan(conv_chan), .conv_done(conv_done),
    .conv_result(conv_result), .irq(irq)
  );

  function automatic logic [9:0] f(logic [3:0] ch, int s);
    return 10'((int'(ch) * 37 + s) % 1024);
  endfunction

  // converter model and channel monitor (scoreboard pop side)
  always @(negedge clk) begin
    conv_done = 0;
    if (m_cnt > 0) begin
      m_cnt--;
      if (m_cnt == 0) begin
        conv_done = 1;
        conv_result = f(m_chan, salt);
      end
    end
    if (conv_start) begin
      m_chan = conv_chan;
      m_cnt = 3;
      conv_cnt++;
      if (chk_en) begin
        checks++;
        if (exp_chan.size() == 0) begin
          errors++;
          $display("FAIL R2 unexpected start actual=%0d expected=none", conv_chan);
        end else begin
          logic [3:0] e;
          e = exp_chan.pop_front();
          if (e !== conv_chan) begin
            errors++;
            $display("FAIL R2/R4 channel order actual=%0d expected=%0d", conv_chan, e);
          end
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  // driver side: expected channel stream into the scoreboard queue
  task automatic expect_chans(input logic [3:0] c[]);
    foreach (c[i]) exp_chan.push_back(c[i]);
  endtask

  task automatic settle(input int n, input string tag);
    repeat (n) @(negedge clk);
    chk(tag, exp_chan.size(), 0);
  endtask

  task automatic rd_chk(input logic [4:0] a, input logic [31:0] exp, input string tag);
    logic [31:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int c0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int n = 0; n < 4; n++) rd_chk(5'(16 + 4*n + 3), 32'h1, "R1 fstat empty after reset");
    rd_chk(5'd7, 0, "R1 overflow clear");
    rd_chk(5'd8, 0, "R1 underflow clear");
    rd_chk(5'd6, 0, "R1 status clear");
    chk("R1 irq low", irq, 0);
    chk("R1 no conversion", conv_cnt, 0);

    // R2 R3 R8 R12: seq1 stops at end bit on step 2, interrupt there
    wr(5'd20, 32'h0000_9273);
    wr(5'd21, 32'h0000_0600);
    wr(5'd2, 32'h0000_00FF);
    wr(5'd0, 32'h2);
    wr(5'd5, 32'h2);
    expect_chans('{4'd3, 4'd7, 4'd2});
    wr(5'd3, 32'h2);
    settle(80, "R2 seq1 stops after end step");
    chk("R8 irq from interrupt step", irq, 4'b0010);
    rd_chk(5'd6, 32'h2, "R8 status is raw and mask");
    rd_chk(5'd23, 32'h30, "R12 fstat count three");
    rd_chk(5'd22, 32'(f(3, salt)), "R3 seq1 result 0");
    rd_chk(5'd22, 32'(f(7, salt)), "R3 seq1 result 1");
    rd_chk(5'd22, 32'(f(2, salt)), "R3 seq1 result 2");
    rd_chk(5'd23, 32'h1, "R12 fstat empty after drain");
    wr(5'd6, 32'h2);
    chk("R9 status write clears irq", irq, 0);

    // R4 priority order: seq2 (0), seq3 (1), seq0 (2)
    wr(5'd16, 32'h41); wr(5'd17, 32'h20);
    wr(5'd24, 32'h65); wr(5'd25, 32'h20);
    wr(5'd28, 32'h8);  wr(5'd29, 32'h0);
    wr(5'd2, 32'h4E);
    wr(5'd0, 32'hD);
    expect_chans('{4'd5, 4'd6, 4'd8, 4'd1, 4'd4});
    wr(5'd3, 32'hD);
    settle(120, "R4 all prioritized conversions seen");
    rd_chk(5'd26, 32'(f(5, salt)), "R3 seq2 result 0");
    rd_chk(5'd26, 32'(f(6, salt)), "R3 seq2 result 1");
    rd_chk(5'd30, 32'(f(8, salt)), "R3 seq3 result");
    rd_chk(5'd18, 32'(f(1, salt)), "R3 seq0 result 0");
    rd_chk(5'd18, 32'(f(4, salt)), "R3 seq0 result 1");

    // R5 disabled sequence ignores trigger
    c0 = conv_cnt;
    wr(5'd3, 32'h2);
    settle(40, "R5 no queue activity");
    chk("R5 disabled seq1 not started", conv_cnt, c0);
    rd_chk(5'd23, 32'h1, "R5 seq1 fifo still empty");

    // R11 underflow
    rd_chk(5'd22, 0, "R11 empty read returns zero");
    rd_chk(5'd8, 32'h2, "R11 underflow flag set");
    wr(5'd8, 32'h2);
    rd_chk(5'd8, 0, "R11 underflow cleared");

    // R10 overflow on depth-1 seq3
    expect_chans('{4'd8});
    wr(5'd3, 32'h8);
    settle(30, "R10 first seq3 run");
    salt = 300;
    expect_chans('{4'd8});
    wr(5'd3, 32'h8);
    settle(30, "R10 second seq3 run");
    rd_chk(5'd7, 32'h8, "R10 overflow flag");
    rd_chk(5'd31, 32'h12, "R12 full bit and count one");
    rd_chk(5'd30, 32'(f(8, 17)), "R10 first sample kept");
    wr(5'd7, 32'h8);
    rd_chk(5'd7, 0, "R10 overflow cleared");

    // R8 R9 stale raw cleared by mask enable
    wr(5'd5, 32'h0);
    wr(5'd0, 32'h2);
    expect_chans('{4'd3, 4'd7, 4'd2});
    wr(5'd3, 32'h2);
    settle(80, "R8 seq1 rerun");
    chk("R8 masked irq low", irq, 0);
    rd_chk(5'd4, 32'h2, "R8 raw bit set");
    rd_chk(5'd6, 0, "R8 masked status zero");
    wr(5'd5, 32'h2);
    rd_chk(5'd4, 0, "R9 mask enable clears stale raw");
    chk("R9 irq low after mask enable", irq, 0);
    for (int i = 0; i < 3; i++) rd_chk(5'd22, 32'(f(i == 0 ? 3 : i == 1 ? 7 : 2, salt)), "R3 seq1 drain");

    // R7 retrigger mid-run on 8-step seq0 (no end bit: runs all 8 steps)
    wr(5'd16, 32'h7654_3210); wr(5'd17, 32'h0);
    wr(5'd0, 32'h1);
    c0 = conv_cnt;
    for (int p = 0; p < 2; p++)
      for (int i = 0; i < 8; i++) exp_chan.push_back(4'(i));
    wr(5'd3, 32'h1);
    repeat (10) @(negedge clk);
    wr(5'd3, 32'h1);
    settle(150, "R7 two full passes");
    chk("R7 sixteen conversions", conv_cnt - c0, 16);
    rd_chk(5'd19, 32'h82, "R12 full with count eight");
    rd_chk(5'd7, 32'h1, "R10 second pass overflowed");
    for (int i = 0; i < 8; i++) rd_chk(5'd18, 32'(f(4'(i), salt)), "R2 seq0 step order");
    wr(5'd7, 32'h1);

    // R6 external select 1 on seq2
    wr(5'd1, 32'h100);
    wr(5'd0, 32'h4);
    expect_chans('{4'd5, 4'd6});
    @(negedge clk); ext_trig = 4'b0001;
    @(negedge clk); ext_trig = 4'b0000;
    settle(40, "R6 external line starts seq2");
    rd_chk(5'd27, 32'h20, "R6 seq2 two results");
    c0 = conv_cnt;
    @(negedge clk); ext_trig = 4'b0010;
    @(negedge clk); ext_trig = 4'b0000;
    settle(30, "R6 unselected line");
    chk("R6 unselected line ignored", conv_cnt, c0);
    rd_chk(5'd26, 32'(f(5, salt)), "R3 seq2 ext result");

    // R6 always trigger on seq3, R5 disable stops it
    chk_en = 0;
    wr(5'd1, 32'hF100);
    c0 = conv_cnt;
    wr(5'd0, 32'h8);
    repeat (60) @(negedge clk);
    chk("R6 always mode rescans", (conv_cnt - c0) >= 5, 1);
    wr(5'd0, 32'h0);
    repeat (20) @(negedge clk);
    c0 = conv_cnt;
    repeat (30) @(negedge clk);
    chk("R5 disable stops rescans", conv_cnt, c0);
    chk_en = 1;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule